// File: doc/BRIEF.md
# Frame-Synced Serial Result Port

This block delivers an 8-bit straight-binary conversion result to a host over a three-wire link. The host supplies a free-running serial clock; the block answers with an active-low frame sync and one data bit per serial clock. It also drives a separate active-high enable that tells a pad-level driver when the data line should leave high impedance. All logic runs on one fast system clock. The serial clock is treated as an ordinary input: it is brought through a two-flop synchronizer and its edges are found by comparing successive samples.

A one-cycle conversion-done strobe loads the result word and arms the port. The next detected serial-clock rising edge opens the frame: frame sync goes low and the MSB appears with the enable high. Each later rising edge presents the next bit, MSB first. The enable drops on the falling edge of the 8th serial clock, and frame sync returns high on the 9th rising edge. If the 9th clock never arrives, a convert-start falling-edge strobe ends the frame. The port does not depend on the converter being powered, so it keeps working while the converter is powered down.

The controller has four states. ST_IDLE means nothing is pending. ST_ARMED means a result is loaded. ST_SHIFT means frame sync is low and the enable is high. ST_TAIL means frame sync is low and the enable is low. The transitions are:
- IDLE→ARMED on a done strobe.
- ARMED→ARMED on a done strobe (the word is reloaded).
- ARMED→SHIFT on a serial rising edge.
- SHIFT→SHIFT on each rising edge until the 8th bit is out.
- SHIFT→TAIL on the falling edge of the 8th clock.
- TAIL→IDLE on the 9th rising edge.
- SHIFT→IDLE or TAIL→IDLE on a convert-start strobe.

Top module: `frame_serial_out`

## Requirements
- R1: After reset, and whenever no result is pending, `fsync_o` is 1, `sdata_oe_o` is 0 and `sdata_o` is 0. Serial-clock edges with no result pending leave these values unchanged.
- R2: After a done strobe, the first detected serial-clock rising edge drives `fsync_o` to 0 and `sdata_oe_o` to 1. The outputs change on the third system-clock edge after the serial clock rises: two synchronizer stages plus the state register.
- R3: On that first rising edge `sdata_o` shows bit 7 of the loaded word. Rising edge k (k = 1..8) of the frame shows bit 8−k.
- R4: `sdata_o` holds its value between rising edges. Serial-clock falling edges before the 8th do not change it.
- R5: On the falling edge of the 8th serial clock of the frame, `sdata_oe_o` goes to 0 and `sdata_o` to 0, while `fsync_o` stays at 0.
- R6: On the 9th rising edge `fsync_o` returns to 1 and the port goes idle. Further serial clocks start no new frame until another done strobe arrives.
- R7: A convert-start strobe while the frame is open (`fsync_o` is 0) forces `fsync_o` to 1 and `sdata_oe_o` to 0 on the next system clock, and the frame is abandoned.
- R8: A done strobe while the frame is open is ignored. The frame continues with the original word, and the port is idle, not armed, after the frame ends.
- R9: A done strobe while the port is armed replaces the loaded word. If it falls in the same cycle as a detected rising edge, the word is reloaded and the frame waits for the next rising edge.
- R10: A convert-start strobe in the same system cycle as the detected 9th rising edge leaves the port idle with `fsync_o` at 1, exactly as either event alone would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Host serial clock, asynchronous to clk |
| done_stb | input | 1 | One-cycle conversion-done strobe |
| done_word | input | 8 | Conversion result, valid with done_stb |
| cnv_fall_stb | input | 1 | One-cycle strobe marking a convert-start falling edge |
| fsync_o | output | 1 | Frame sync, active low, idles high |
| sdata_o | output | 1 | Serial data bit, MSB first |
| sdata_oe_o | output | 1 | Active-high enable for the external data driver |

## Verification
Two pairs of functions can meet in one system cycle. The first pair is the convert-start recovery and the 9th-edge frame end. The bench raises the serial clock and waits two system edges, so the synchronized rising edge is being seen. It then places the convert-start strobe in exactly that cycle and requires frame sync high, the enable low and no new frame on later serial clocks. The second pair is a done strobe arriving on the very cycle a rising edge is detected while armed. There the word must be reloaded and the frame must open only on the following rising edge, carrying the new word. Every one of the 256 result words is shifted out, and each bit is compared against the word computed in the bench.

// File: rtl/fso_pkg.sv
package fso_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } fso_state_e;
endpackage

// File: rtl/fso_edge_det.sv
module fso_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[DEPTH-2:0], async_in};
        end
    end

    assign rise_o = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
    assign fall_o = ~pipe_q[DEPTH-2] & pipe_q[DEPTH-1];

    assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
endmodule

// File: rtl/fso_shreg.sv
module fso_shreg #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [W-1:0]     word_i,
    input  logic             start_i,
    input  logic             step_i,
    output logic             msb_o,
    output logic [$clog2(W+1)-1:0] count_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  bits_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            bits_q <= word_i;
            cnt_q  <= '0;
        end else if (start_i) begin
            cnt_q  <= CW'(1);
        end else if (step_i) begin
            bits_q <= {bits_q[W-2:0], 1'b0};
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign msb_o   = bits_q[W-1];
    assign count_o = cnt_q;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(W));
    assert_step_needs_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cnt_q != '0));
endmodule

// File: rtl/frame_serial_out.sv
module frame_serial_out #(
    parameter int W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_in,
    input  logic         done_stb,
    input  logic [W-1:0] done_word,
    input  logic         cnv_fall_stb,
    output logic         fsync_o,
    output logic         sdata_o,
    output logic         sdata_oe_o
);
    import fso_pkg::*;

    localparam int CW = $clog2(W + 1);

    fso_state_e    st_q, st_d;
    logic          sclk_rise, sclk_fall;
    logic          ld, start, step;
    logic          msb;
    logic [CW-1:0] cnt;

    fso_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise_o   (sclk_rise),
        .fall_o   (sclk_fall)
    );

    fso_shreg #(.W(W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ld),
        .word_i  (done_word),
        .start_i (start),
        .step_i  (step),
        .msb_o   (msb),
        .count_o (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        ld    = 1'b0;
        start = 1'b0;
        step  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (done_stb) begin
                    ld   = 1'b1;
                    st_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (done_stb) begin
                    ld = 1'b1;
                end else if (sclk_rise) begin
                    start = 1'b1;
                    st_d  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (cnv_fall_stb) begin
                    st_d = ST_IDLE;
                end else if (sclk_rise && cnt < CW'(W)) begin
                    step = 1'b1;
                end else if (sclk_fall && cnt == CW'(W)) begin
                    st_d = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (cnv_fall_stb || sclk_rise) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fsync_o    = 1'b1;
        sdata_oe_o = 1'b0;
        sdata_o    = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_ARMED: begin
                fsync_o = 1'b1;
            end
            ST_SHIFT: begin
                fsync_o    = 1'b0;
                sdata_oe_o = 1'b1;
                sdata_o    = msb;
            end
            ST_TAIL: begin
                fsync_o = 1'b0;
            end
            default: fsync_o = 1'b1;
        endcase
    end

    assert_fsync_fall_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync_o) |-> $past(sclk_rise));
    assert_oe_rise_with_fsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe_o) |-> $fell(fsync_o));
    assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe_o && $past(sdata_oe_o) && !$past(sclk_rise)) |-> $stable(sdata_o));
    assert_oe_off_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sdata_oe_o) && !fsync_o) |-> $past(sclk_fall));
    assert_fsync_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_o) |-> $past(sclk_rise || cnv_fall_stb));
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_fall_stb && !fsync_o) |=> (fsync_o && !sdata_oe_o));
    assert_oe_inside_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe_o |-> !fsync_o);
endmodule

// File: tb/frame_serial_out_bench.sv
module frame_serial_out_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_in = 1'b0;
    logic         done_stb = 1'b0;
    logic [W-1:0] done_word = '0;
    logic         cnv_fall_stb = 1'b0;
    logic         fsync_o, sdata_o, sdata_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frame_serial_out #(.W(W)) u_frame_serial_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_in      (sclk_in),
        .done_stb     (done_stb),
        .done_word    (done_word),
        .cnv_fall_stb (cnv_fall_stb),
        .fsync_o      (fsync_o),
        .sdata_o      (sdata_o),
        .sdata_oe_o   (sdata_oe_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic phase(input logic lvl);
        @(negedge clk) sclk_in = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_done(input logic [W-1:0] w);
        @(negedge clk);
        done_stb  = 1'b1;
        done_word = w;
        @(negedge clk);
        done_stb  = 1'b0;
    endtask

    task automatic pulse_cnv();
        @(negedge clk) cnv_fall_stb = 1'b1;
        @(negedge clk) cnv_fall_stb = 1'b0;
    endtask

    task automatic idle_chk(input string tag);
        chk({tag, " fsync"}, int'(fsync_o), 1);
        chk({tag, " oe"}, int'(sdata_oe_o), 0);
        chk({tag, " data"}, int'(sdata_o), 0);
    endtask

    task automatic full_frame(input logic [W-1:0] w);
        pulse_done(w);
        for (int k = 1; k <= W; k++) begin
            phase(1'b1);
            chk("R2 fsync low", int'(fsync_o), 0);
            chk("R2 oe high", int'(sdata_oe_o), 1);
            chk("R3 bit", int'(sdata_o), int'(w[W-k]));
            phase(1'b0);
            if (k < W) begin
                chk("R4 held after fall", int'(sdata_o), int'(w[W-k]));
            end else begin
                chk("R5 oe off", int'(sdata_oe_o), 0);
                chk("R5 fsync still low", int'(fsync_o), 0);
            end
        end
        phase(1'b1);
        chk("R6 fsync high on 9th", int'(fsync_o), 1);
        phase(1'b0);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_chk("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1 after reset");
        phase(1'b1);
        idle_chk("R1 idle rise");
        phase(1'b0);

        for (int v = 0; v < 256; v++) begin
            full_frame(W'(v));
        end

        phase(1'b1);
        idle_chk("R6 no new frame");
        phase(1'b0);

        pulse_done(8'hA5);
        phase(1'b1);
        phase(1'b0);
        pulse_done(8'h3C);
        for (int k = 2; k <= W; k++) begin
            phase(1'b1);
            chk("R8 original bit", int'(sdata_o), int'(k == 2 ? 0 : (8'hA5 >> (W - k)) & 1));
            phase(1'b0);
        end
        phase(1'b1);
        chk("R8 fsync released", int'(fsync_o), 1);
        phase(1'b0);
        phase(1'b1);
        idle_chk("R8 not armed");
        phase(1'b0);

        pulse_done(8'hF0);
        phase(1'b1);
        phase(1'b0);
        phase(1'b1);
        pulse_cnv();
        idle_chk("R7 abort shift");
        phase(1'b0);
        phase(1'b1);
        idle_chk("R7 abandoned");
        phase(1'b0);

        pulse_done(8'h81);
        for (int k = 1; k <= W; k++) begin
            phase(1'b1);
            phase(1'b0);
        end
        chk("R7 tail fsync", int'(fsync_o), 0);
        pulse_cnv();
        idle_chk("R7 abort tail");

        pulse_done(8'h0F);
        pulse_done(8'hC3);
        phase(1'b1);
        chk("R9 reload msb", int'(sdata_o), 1);
        chk("R9 frame open", int'(fsync_o), 0);
        phase(1'b0);
        phase(1'b1);
        chk("R9 reload bit6", int'(sdata_o), 1);
        pulse_cnv();
        phase(1'b0);

        pulse_done(8'h55);
        @(negedge clk) sclk_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) done_stb = 1'b1;
        done_word = 8'h99;
        @(posedge clk);
        @(negedge clk) done_stb = 1'b0;
        chk("R9 same-cycle defers", int'(fsync_o), 1);
        repeat (2) @(negedge clk);
        phase(1'b0);
        phase(1'b1);
        chk("R9 new word msb", int'(sdata_o), 1);
        phase(1'b0);
        phase(1'b1);
        chk("R9 new word bit6", int'(sdata_o), 0);
        pulse_cnv();
        phase(1'b0);

        pulse_done(8'hFF);
        for (int k = 1; k <= W; k++) begin
            phase(1'b1);
            phase(1'b0);
        end
        @(negedge clk) sclk_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) cnv_fall_stb = 1'b1;
        @(posedge clk);
        @(negedge clk) cnv_fall_stb = 1'b0;
        idle_chk("R10 coincide");
        repeat (2) @(negedge clk);
        phase(1'b0);
        phase(1'b1);
        idle_chk("R10 stays idle");
        phase(1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule